// File: doc/BRIEF.md
# Address-Match Breakpoint Channel Controller

This block watches the data accesses a CPU places on its bus and compares each one against a small set of programmed breakpoint channels. Each channel holds an enable, an allowed access direction, a watched length, a compare address and an address mask. When an access overlaps the watched range in an allowed direction, the channel's bit in a shared match-flag register is set. A break request carrying a fixed exception code goes to the CPU while any flagged channel has break-on-match enabled.

Software programs the unit through a plain 32-bit register port. A debug handler reads the match flags to see which channels fired. It drops the enables of the channels it is servicing and clears each flag it has handled by writing that bit as 0. It then sets the enable again only on the channels it wants to keep armed. The flags are sticky, so a burst of matching accesses leaves a single pending record per channel.

There is no state machine. The only sequential state is the register file and the flag register, and the break request is a combinational function of them.

Top module: `brk_unit`

## Requirements
- R1: The register map places channel n at byte offset 0x20*n. Within a channel, control is at +0x0, action at +0x4, compare address at +0x8 and address mask at +0xC. The match flags are at 0x600 and the shared control word is at 0x620. After reset every register reads 0, except each action register, which reads 0x3.
- R2: A register that was written reads back the written value in the following cycle. Bits without a function read as 0: control keeps bits [5:4], [2:1] and [0], action keeps bits [1:0], and the flag register keeps one bit per channel. Offsets that are not mapped read 0.
- R3: Control bit 0 enables the channel. A channel with this bit clear never sets its flag, and writing 0 to its control and address registers disables it completely.
- R4: Control bits [2:1] give the allowed direction. Bit 1 allows reads and bit 2 allows writes, so 01 means read only, 10 write only and 11 both. An access in a direction that is not allowed does not match.
- R5: Control bits [5:4] give the watched length as 0=1, 1=2, 2=4 or 3=8 bytes. The access size input uses the same code, and accesses are naturally aligned. A match needs the access's byte range to overlap the watched range.
- R6: The compare address bits below the watched length are ignored, so the watched range is always aligned to its length.
- R7: A mask bit of 1 removes that address bit from the comparison. A mask of 0 requires all the remaining bits to be equal.
- R8: A matching access sets flag bit i in the clock cycle after the access, and the bit stays set across later accesses.
- R9: A write to the flag register clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a flag.
- R10: If a match and a clearing write to the flag register fall in the same cycle, the match wins and the flag ends up set.
- R11: The break request is high exactly while some flagged channel has action bit 0 set. While it is high the exception code output reads 0x1E0, and otherwise it reads 0. Action bit 1 is stored but does not change matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| acc_valid | input | 1 | A CPU data access is present this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_size | input | 2 | Access size code (0=1, 1=2, 2=4, 3=8 bytes) |
| acc_addr | input | 32 | Access byte address |
| match_flags | output | NCH | Sticky per-channel match flags |
| brk_req | output | 1 | Break exception request |
| brk_code | output | 12 | Exception code, 0x1E0 while requesting |

## Verification
The checker watches four things on every cycle. It checks that a set flag only falls after a write of 0 to its bit, that a flag only rises after an access while its channel is enabled, that the exception code tracks the request, and that the request never appears while no flag is set. The ways an access can overlap a range under the different lengths, the misaligned compare addresses, the masks and the direction filtering all depend on values that were programmed earlier. These can only be shown by the bench's scenarios, which compare against the behavioural model on every clock. The same applies to the race between a match and a clear, and to read-back of every field.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam logic [11:0] OFS_FLAGS  = 12'h600;
    localparam logic [11:0] OFS_SHARED = 12'h620;
    localparam int          CH_STRIDE  = 32;

    typedef enum logic [1:0] {
        LEN_1B = 2'd0,
        LEN_2B = 2'd1,
        LEN_4B = 2'd2,
        LEN_8B = 2'd3
    } len_e;

    // bit 0 allows reads, bit 1 allows writes
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_RD   = 2'd1,
        DIR_WR   = 2'd2,
        DIR_RW   = 2'd3
    } dir_e;

    typedef struct packed {
        len_e len;
        dir_e dir;
        logic en;
    } chan_ctrl_t;

    typedef struct packed {
        logic pc_timing;
        logic brk_on_hit;
    } chan_act_t;

endpackage

// File: rtl/brk_chan.sv
module brk_chan
    import brk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_act,
    input  logic          wr_cmp,
    input  logic          wr_mask,
    input  logic [DW-1:0] wdata,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] acc_addr,
    output logic          hit,
    output logic          chan_en,
    output logic          brk_en,
    output logic [DW-1:0] rd_ctrl,
    output logic [DW-1:0] rd_act,
    output logic [DW-1:0] rd_cmp,
    output logic [DW-1:0] rd_mask
);

    chan_ctrl_t    ctrl_q;
    chan_act_t     act_q;
    logic [AW-1:0] cmp_q;
    logic [AW-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            act_q  <= '{pc_timing: 1'b1, brk_on_hit: 1'b1};
            cmp_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.en  <= wdata[0];
                ctrl_q.dir <= dir_e'(wdata[2:1]);
                ctrl_q.len <= len_e'(wdata[5:4]);
            end
            if (wr_act) begin
                act_q.brk_on_hit <= wdata[0];
                act_q.pc_timing  <= wdata[1];
            end
            if (wr_cmp)  cmp_q  <= wdata[AW-1:0];
            if (wr_mask) mask_q <= wdata[AW-1:0];
        end
    end

    // comparator: the coarser of watched length and access size sets the granule
    logic [1:0]    gran_code;
    logic [AW-1:0] low_bits;
    logic [AW-1:0] care;
    logic          dir_ok;

    always_comb begin
        gran_code = (ctrl_q.len > acc_size) ? ctrl_q.len : acc_size;
        low_bits  = (AW'(1) << gran_code) - AW'(1);
        care      = ~(mask_q | low_bits);
        dir_ok    = acc_write ? ctrl_q.dir[1] : ctrl_q.dir[0];
        hit       = acc_valid && ctrl_q.en && dir_ok &&
                    (((acc_addr ^ cmp_q) & care) == '0);
    end

    assign chan_en = ctrl_q.en;
    assign brk_en  = act_q.brk_on_hit;
    assign rd_ctrl = {{(DW-6){1'b0}}, ctrl_q.len, 1'b0, ctrl_q.dir, ctrl_q.en};
    assign rd_act  = {{(DW-2){1'b0}}, act_q.pc_timing, act_q.brk_on_hit};
    assign rd_cmp  = DW'(cmp_q);
    assign rd_mask = DW'(mask_q);

endmodule

// File: rtl/brk_flags.sv
module brk_flags #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit,
    input  logic           wr_flags,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] flags
);

    logic [NCH-1:0] kept;

    always_comb begin
        kept = wr_flags ? (flags & wdata) : flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= kept | hit;
    end

endmodule

// File: rtl/brk_unit.sv
module brk_unit
    import brk_pkg::*;
#(
    parameter int          NCH       = 2,
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          RAW       = 12,
    parameter logic [11:0] TRAP_CODE = 12'h1E0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           acc_valid,
    input  logic           acc_write,
    input  logic [1:0]     acc_size,
    input  logic [AW-1:0]  acc_addr,
    output logic [NCH-1:0] match_flags,
    output logic           brk_req,
    output logic [11:0]    brk_code
);

    localparam int IDXW = RAW - 5;

    logic [NCH-1:0] hit;
    logic [NCH-1:0] chan_en;
    logic [NCH-1:0] brk_en;
    logic [DW-1:0]  rd_ctrl [NCH];
    logic [DW-1:0]  rd_act  [NCH];
    logic [DW-1:0]  rd_cmp  [NCH];
    logic [DW-1:0]  rd_mask [NCH];
    logic [DW-1:0]  shared_q;

    logic sel_flags;
    logic sel_shared;

    assign sel_flags  = (reg_addr[RAW-1:2] == OFS_FLAGS[RAW-1:2]);
    assign sel_shared = (reg_addr[RAW-1:2] == OFS_SHARED[RAW-1:2]);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic in_chan;
        assign in_chan = reg_wr && (reg_addr[RAW-1:5] == IDXW'(g)) && !reg_addr[4];

        brk_chan #(.AW(AW), .DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl   (in_chan && reg_addr[3:2] == 2'd0),
            .wr_act    (in_chan && reg_addr[3:2] == 2'd1),
            .wr_cmp    (in_chan && reg_addr[3:2] == 2'd2),
            .wr_mask   (in_chan && reg_addr[3:2] == 2'd3),
            .wdata     (reg_wdata),
            .acc_valid (acc_valid),
            .acc_write (acc_write),
            .acc_size  (acc_size),
            .acc_addr  (acc_addr),
            .hit       (hit[g]),
            .chan_en   (chan_en[g]),
            .brk_en    (brk_en[g]),
            .rd_ctrl   (rd_ctrl[g]),
            .rd_act    (rd_act[g]),
            .rd_cmp    (rd_cmp[g]),
            .rd_mask   (rd_mask[g])
        );
    end

    brk_flags #(.NCH(NCH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .wr_flags (reg_wr && sel_flags),
        .wdata    (reg_wdata[NCH-1:0]),
        .flags    (match_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    shared_q <= '0;
        else if (reg_wr && sel_shared) shared_q <= reg_wdata;
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_flags) begin
            reg_rdata[NCH-1:0] = match_flags;
        end else if (sel_shared) begin
            reg_rdata = shared_q;
        end else if (!reg_addr[4]) begin
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr[RAW-1:5] == IDXW'(i)) begin
                    unique case (reg_addr[3:2])
                        2'd0: reg_rdata = rd_ctrl[i];
                        2'd1: reg_rdata = rd_act[i];
                        2'd2: reg_rdata = rd_cmp[i];
                        2'd3: reg_rdata = rd_mask[i];
                    endcase
                end
            end
        end
    end

    assign brk_req  = |(match_flags & brk_en);
    assign brk_code = brk_req ? TRAP_CODE : 12'h000;

endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
    parameter int NCH = 2,
    parameter int RAW = 12,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_wr,
    input logic [RAW-1:0] reg_addr,
    input logic [DW-1:0]  reg_wdata,
    input logic           acc_valid,
    input logic [NCH-1:0] match_flags,
    input logic [NCH-1:0] chan_en,
    input logic           brk_req,
    input logic [11:0]    brk_code
);

    logic flag_wr;
    assign flag_wr = reg_wr && (reg_addr[RAW-1:2] == brk_pkg::OFS_FLAGS[RAW-1:2]);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R8
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (match_flags[g] && !(flag_wr && !reg_wdata[g])) |=> match_flags[g]);
        // R3
        dis_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!match_flags[g] && !(acc_valid && chan_en[g])) |=> !match_flags[g]);
        // R8
        rise_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(match_flags[g]) |-> $past(acc_valid));
    end

    // R11
    code_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (brk_code == 12'h1E0));
    // R11
    code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_req |-> (brk_code == 12'h000));
    // R11
    no_req_without_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flags == '0) |-> !brk_req);

endmodule

bind brk_unit brk_unit_chk #(.NCH(NCH), .RAW(RAW), .DW(DW)) u_brk_unit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .acc_valid   (acc_valid),
    .match_flags (match_flags),
    .chan_en     (chan_en),
    .brk_req     (brk_req),
    .brk_code    (brk_code)
);

// File: tb/test_brk_unit.sv
module test_brk_unit;

    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_addr = '0;
    logic [NCH-1:0] match_flags;
    logic        brk_req;
    logic [11:0] brk_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 0;

    always #2 clk = ~clk;

    brk_unit i_brk_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_size(acc_size), .acc_addr(acc_addr),
        .match_flags(match_flags), .brk_req(brk_req), .brk_code(brk_code)
    );

    // behavioural reference model
    logic [31:0] m_ctrl [NCH];
    logic [31:0] m_act  [NCH];
    logic [31:0] m_cmp  [NCH];
    logic [31:0] m_mask [NCH];
    logic [31:0] m_shared;
    logic [NCH-1:0] m_flags;

    function automatic bit m_hit(int c);
        logic [31:0] plen, pbase, alen;
        if (!acc_valid || !m_ctrl[c][0]) return 0;
        if (acc_write ? !m_ctrl[c][2] : !m_ctrl[c][1]) return 0;
        plen  = 32'd1 << m_ctrl[c][5:4];
        alen  = 32'd1 << acc_size;
        pbase = m_cmp[c] & ~(plen - 32'd1);
        for (int i = 0; i < int'(alen); i++)
            for (int j = 0; j < int'(plen); j++)
                if ((((acc_addr + 32'(i)) ^ (pbase + 32'(j))) & ~m_mask[c]) == 32'd0)
                    return 1;
        return 0;
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        int w;
        w = int'(a) & ~3;
        if (w == 'h600) return 32'(m_flags);
        if (w == 'h620) return m_shared;
        for (int c = 0; c < NCH; c++) begin
            if (w == c * 32)      return m_ctrl[c] & 32'h37;
            if (w == c * 32 + 4)  return m_act[c] & 32'h3;
            if (w == c * 32 + 8)  return m_cmp[c];
            if (w == c * 32 + 12) return m_mask[c];
        end
        return 32'd0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_ctrl[c] <= 0; m_act[c] <= 3; m_cmp[c] <= 0; m_mask[c] <= 0;
            end
            m_shared <= 0;
            m_flags  <= 0;
        end else begin
            logic [NCH-1:0] nf;
            int w;
            w  = int'(reg_addr) & ~3;
            nf = m_flags;
            if (reg_wr && w == 'h600) nf = nf & reg_wdata[NCH-1:0];
            for (int c = 0; c < NCH; c++) if (m_hit(c)) nf[c] = 1'b1;
            m_flags <= nf;
            if (reg_wr) begin
                if (w == 'h620) m_shared <= reg_wdata;
                for (int c = 0; c < NCH; c++) begin
                    if (w == c * 32)      m_ctrl[c] <= reg_wdata;
                    if (w == c * 32 + 4)  m_act[c]  <= reg_wdata;
                    if (w == c * 32 + 8)  m_cmp[c]  <= reg_wdata;
                    if (w == c * 32 + 12) m_mask[c] <= reg_wdata;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            logic req;
            req = 1'b0;
            for (int c = 0; c < NCH; c++) if (m_flags[c] && m_act[c][0]) req = 1'b1;
            chk("R8 flags vs model", 32'(match_flags), 32'(m_flags));
            chk("R11 req vs model", 32'(brk_req), 32'(req));
            chk("R11 code vs model", 32'(brk_code), req ? 32'h1E0 : 32'h0);
            chk("R2 rdata vs model", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic acc(bit w, logic [1:0] sz, logic [31:0] a);
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_write = w; acc_size = sz; acc_addr = a;
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic flag_chk(string tag, logic [NCH-1:0] exp);
        @(negedge clk);
        chk(tag, 32'(match_flags), 32'(exp));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1 reset values and map
        rd_chk("R1 ctrl0 reset", 12'h000, 32'h0);
        rd_chk("R1 act0 reset", 12'h004, 32'h3);
        rd_chk("R1 act1 reset", 12'h024, 32'h3);
        rd_chk("R1 mask1 reset", 12'h02C, 32'h0);
        rd_chk("R1 flags reset", 12'h600, 32'h0);
        rd_chk("R1 shared reset", 12'h620, 32'h0);

        // R2 read-back and unused bits
        wr(12'h020, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl1 unused bits zero", 12'h020, 32'h37);
        rd_chk("R2 unmapped offset", 12'h010, 32'h0);
        wr(12'h620, 32'hA5A5_0001);
        rd_chk("R2 shared read-back", 12'h620, 32'hA5A5_0001);

        // ch0: read only, 4 bytes at 0x1000; ch1: write only, 2 bytes at 0x2002
        wr(12'h000, 32'h23);
        wr(12'h008, 32'h1000);
        rd_chk("R2 ctrl0 read-back", 12'h000, 32'h23);
        wr(12'h020, 32'h15);
        wr(12'h028, 32'h2002);

        acc(0, 2'd2, 32'h1000);
        flag_chk("R8 read hit sets flag0", 2'b01);
        chk("R11 break request", 32'(brk_req), 32'h1);
        chk("R11 break code", 32'(brk_code), 32'h1E0);
        acc(1, 2'd2, 32'h3000);
        flag_chk("R8 flag stays set", 2'b01);
        wr(12'h600, 32'hFFFF_FFFF);
        flag_chk("R9 write of ones does not clear", 2'b01);
        wr(12'h600, 32'h0);
        flag_chk("R9 write zero clears", 2'b00);
        chk("R11 no request when clear", 32'(brk_req), 32'h0);

        // R4 direction
        acc(1, 2'd2, 32'h1000);
        flag_chk("R4 write ignored by read-only channel", 2'b00);

        // R5 overlap
        acc(0, 2'd0, 32'h1003);
        flag_chk("R5 last byte overlaps", 2'b01);
        wr(12'h600, 32'h0);
        acc(0, 2'd0, 32'h1004);
        flag_chk("R5 byte past range", 2'b00);
        acc(0, 2'd3, 32'h0FF8);
        flag_chk("R5 8-byte below range", 2'b00);
        acc(0, 2'd3, 32'h1000);
        flag_chk("R5 8-byte covering range", 2'b01);
        wr(12'h600, 32'h0);
        acc(1, 2'd0, 32'h2001);
        flag_chk("R5 byte before 2-byte range", 2'b00);
        acc(1, 2'd2, 32'h2000);
        flag_chk("R5 word covers ch1 range", 2'b10);
        wr(12'h600, 32'h1);
        flag_chk("R9 clear bit1 only", 2'b00);

        // R4 both directions, both channels
        wr(12'h020, 32'h37);
        wr(12'h028, 32'h1000);
        acc(0, 2'd0, 32'h1001);
        flag_chk("R4 read matches both channels", 2'b11);
        wr(12'h600, 32'h2);
        flag_chk("R9 clear bit0 only", 2'b10);
        wr(12'h600, 32'h0);

        // R6 misaligned compare address
        wr(12'h008, 32'h1002);
        acc(0, 2'd0, 32'h1000);
        flag_chk("R6 low compare bits ignored", 2'b11);
        wr(12'h600, 32'h0);
        wr(12'h020, 32'h0);

        // R7 mask
        wr(12'h00C, 32'h0000_F000);
        acc(0, 2'd2, 32'h5000);
        flag_chk("R7 masked bits ignored", 2'b01);
        wr(12'h600, 32'h0);
        wr(12'h00C, 32'h0);
        acc(0, 2'd2, 32'h5000);
        flag_chk("R7 zero mask exact", 2'b00);

        // R3 enable
        wr(12'h000, 32'h22);
        acc(0, 2'd2, 32'h1000);
        flag_chk("R3 disabled channel no match", 2'b00);
        wr(12'h000, 32'h23);

        // R11 break-on-match enable
        wr(12'h004, 32'h2);
        acc(0, 2'd2, 32'h1000);
        flag_chk("R11 flag set without break enable", 2'b01);
        chk("R11 no request without enable", 32'(brk_req), 32'h0);
        chk("R11 code idle", 32'(brk_code), 32'h0);
        wr(12'h004, 32'h3);
        @(negedge clk);
        chk("R11 request after enable restored", 32'(brk_req), 32'h1);
        wr(12'h600, 32'h0);

        // R10 match wins over clear
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 12'h600; reg_wdata = 32'h0;
        acc_valid = 1'b1; acc_write = 1'b0; acc_size = 2'd2; acc_addr = 32'h1000;
        @(posedge clk); #1;
        reg_wr = 1'b0; acc_valid = 1'b0;
        flag_chk("R10 match beats clear", 2'b01);
        wr(12'h600, 32'h0);

        // R3 full disable by zeroing control and address
        wr(12'h000, 32'h0);
        wr(12'h008, 32'h0);
        acc(0, 2'd0, 32'h0);
        flag_chk("R3 zeroed channel no match", 2'b00);
        rd_chk("R3 ctrl0 zero", 12'h000, 32'h0);

        repeat (3) @(posedge clk);
        cmp_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule